// File: doc/BRIEF.md
# MESI Snooping Cache Controller

This block is the coherence engine of one private cache in a bus-based multiprocessor. It holds a small direct-mapped array of single-word lines, each tagged with one of four coherence states: Invalid, Shared (clean, other copies may exist), Exclusive (clean, no other copy) and Modified (dirty, no other copy). It serves processor loads and stores against that array. When the local state cannot satisfy an access, it wins the shared bus and issues a read, a read-for-ownership or a writeback.

While another cache owns the bus, the controller watches every transaction on a snoop port. It answers in the same cycle. It raises its contribution to the wired-OR shared line when it holds a copy of a snooped read. When it holds the only current copy, it supplies the dirty word and inhibits memory. At the closing clock edge it demotes or invalidates its own copy.

Because the shared line is sampled when a read miss completes, a line nobody else holds fills as Exclusive. A later store then upgrades it to Modified without using the bus.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. The first read of any address issues a bus read, and a snooped read of any address gets no shared indication from this cache.
- R2: A read miss issues a bus read (command code 1) at the requested address. The line fills as Exclusive if `bus_shared_in` is low when `bus_done` pulses, and as Shared if it is high. The read returns the word on `bus_rdata`.
- R3: A read of a line held in Modified, Exclusive or Shared returns the stored word. The response is valid one cycle after the request is accepted, and no bus command is issued.
- R4: A store to an Exclusive or Modified line updates the word and leaves the line Modified. The response is valid one cycle after acceptance, and no bus command is issued.
- R5: A store to a line that is Shared or not present issues a read-for-ownership (command code 2). The line ends Modified and holds the stored word.
- R6: `snp_shared_out` is high in the cycle of a snooped bus read (snoop command 1) whose address matches a valid line. It is low for a miss and for any other snoop command.
- R7: A snooped bus read that hits a Modified line raises `snp_flush` in the same cycle with the line's word on `snp_flush_data`, which tells memory to stay silent. The line becomes Shared.
- R8: A snooped read-for-ownership (snoop command 2) that hits a Modified line flushes the word the same way, and the line becomes Invalid.
- R9: A snooped bus read demotes an Exclusive line to Shared without a flush. A snooped read-for-ownership invalidates an Exclusive or Shared line without a flush.
- R10: A miss that displaces a Modified line of another address first issues a writeback (command code 3) carrying the old address and word, then the fill. A displaced Exclusive or Shared line is dropped with no bus transaction.
- R11: Requests use valid/ready. `cpu_req_ready` is low while a request is in progress and during any cycle with `snp_valid` high. A response is held valid with stable data until `cpu_rsp_ready` is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller accepts the request at this edge |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW | Word address of the request |
| cpu_req_wdata | input | DW | Store data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | DW | Loaded word (the stored word for a store) |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_cmd | output | 2 | 0 idle, 1 read, 2 read-for-ownership, 3 writeback |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Writeback data |
| bus_done | input | 1 | One-cycle pulse ending the current transaction |
| bus_rdata | input | DW | Fill data, valid with bus_done |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled with bus_done |
| snp_valid | input | 1 | A transaction of another cache is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | AW | Snooped address |
| snp_shared_out | output | 1 | This cache's input to the wired-OR shared line |
| snp_flush | output | 1 | This cache supplies the data; memory must not respond |
| snp_flush_data | output | DW | Flushed dirty word |

## Verification
Snoop answers are combinational, so the bench reads `snp_shared_out`, `snp_flush` and the flush word shortly after it drives a snoop, within the same cycle. It then looks for the state change only in later accesses, after the edge that ends the snoop cycle. A hit or silent store answers one cycle after the accepting edge. The bench counts falling edges from acceptance to `cpu_rsp_valid` and requires exactly one. A miss answers one cycle after the `bus_done` pulse. There the bench compares the per-command transaction counters of its bus model, read before and after each access, with the traffic the requirement predicts. All outputs are sampled at the falling edge or just after a mid-cycle drive, never at the active edge.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_state_e;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_RD   = 2'd1;
  localparam logic [1:0] CMD_RDX  = 2'd2;
  localparam logic [1:0] CMD_WB   = 2'd3;

  typedef enum logic [2:0] {
    C_IDLE = 3'd0,
    C_ARB  = 3'd1,
    C_WB   = 3'd2,
    C_FILL = 3'd3,
    C_RESP = 3'd4
  } ctrl_state_e;

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int IDXW   = 2,
  parameter int TAGW   = 6,
  parameter int DW     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  // processor-side lookup
  input  logic [IDXW-1:0]  a_idx,
  output line_state_e      a_state,
  output logic [TAGW-1:0]  a_tag,
  output logic [DW-1:0]    a_data,
  // snoop-side lookup
  input  logic [IDXW-1:0]  b_idx,
  output line_state_e      b_state,
  output logic [TAGW-1:0]  b_tag,
  output logic [DW-1:0]    b_data,
  // controller update (full line)
  input  logic             c_we,
  input  logic [IDXW-1:0]  c_idx,
  input  line_state_e      c_state,
  input  logic [TAGW-1:0]  c_tag,
  input  logic [DW-1:0]    c_data,
  // snoop update (state only)
  input  logic             s_we,
  input  logic [IDXW-1:0]  s_idx,
  input  line_state_e      s_state
);

  line_state_e       st_q  [NLINES];
  logic [TAGW-1:0]   tag_q [NLINES];
  logic [DW-1:0]     dat_q [NLINES];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i]  <= LS_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end else if (c_we && (c_idx == IDXW'(i))) begin
        st_q[i]  <= c_state;
        tag_q[i] <= c_tag;
        dat_q[i] <= c_data;
      end else if (s_we && (s_idx == IDXW'(i))) begin
        st_q[i]  <= s_state;
      end
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = dat_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = dat_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAGW = 6,
  parameter int DW   = 32
) (
  input  logic            snp_valid,
  input  logic [1:0]      snp_cmd,
  input  logic [TAGW-1:0] snp_tag,
  input  line_state_e     ln_state,
  input  logic [TAGW-1:0] ln_tag,
  input  logic [DW-1:0]   ln_data,
  output logic            shared_out,
  output logic            flush,
  output logic [DW-1:0]   flush_data,
  output logic            upd_en,
  output line_state_e     upd_state
);

  logic hit;

  always_comb begin
    hit        = snp_valid && (ln_state != LS_I) && (ln_tag == snp_tag);
    shared_out = 1'b0;
    flush      = 1'b0;
    upd_en     = 1'b0;
    upd_state  = ln_state;
    if (hit) begin
      if (snp_cmd == CMD_RD) begin
        shared_out = 1'b1;
        if (ln_state == LS_M) begin
          flush     = 1'b1;
          upd_en    = 1'b1;
          upd_state = LS_S;
        end else if (ln_state == LS_E) begin
          upd_en    = 1'b1;
          upd_state = LS_S;
        end
      end else if (snp_cmd == CMD_RDX) begin
        flush     = (ln_state == LS_M);
        upd_en    = 1'b1;
        upd_state = LS_I;
      end
    end
    flush_data = flush ? ln_data : '0;
  end

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int IDXW = 2,
  parameter int TAGW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req_valid,
  output logic            cpu_req_ready,
  input  logic            cpu_req_write,
  input  logic [AW-1:0]   cpu_req_addr,
  input  logic [DW-1:0]   cpu_req_wdata,
  output logic            cpu_rsp_valid,
  input  logic            cpu_rsp_ready,
  output logic [DW-1:0]   cpu_rsp_rdata,
  input  logic            snp_busy,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic [1:0]      bus_cmd,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_done,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_shared_in,
  output logic [IDXW-1:0] lk_idx,
  input  line_state_e     lk_state,
  input  logic [TAGW-1:0] lk_tag,
  input  logic [DW-1:0]   lk_data,
  output logic            wr_en,
  output line_state_e     wr_state,
  output logic [TAGW-1:0] wr_tag,
  output logic [DW-1:0]   wr_data
);

  ctrl_state_e     st_q, nxt;
  logic            wr_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [DW-1:0]   rsp_q, rsp_d;

  logic            idle, accept, cur_write, tag_hit, victim_dirty;
  logic [AW-1:0]   cur_addr;
  logic [TAGW-1:0] cur_tag;

  always_comb begin
    idle         = (st_q == C_IDLE);
    accept       = idle && cpu_req_valid && !snp_busy;
    cur_write    = idle ? cpu_req_write : wr_q;
    cur_addr     = idle ? cpu_req_addr  : addr_q;
    lk_idx       = cur_addr[IDXW-1:0];
    cur_tag      = cur_addr[AW-1:IDXW];
    tag_hit      = (lk_state != LS_I) && (lk_tag == cur_tag);
    victim_dirty = (lk_state == LS_M) && (lk_tag != cur_tag);
  end

  always_comb begin
    nxt       = st_q;
    rsp_d     = rsp_q;
    wr_en     = 1'b0;
    wr_state  = LS_I;
    wr_tag    = cur_tag;
    wr_data   = lk_data;
    bus_cmd   = CMD_NONE;
    bus_addr  = addr_q;
    bus_wdata = '0;
    unique case (st_q)
      C_IDLE: begin
        if (accept) begin
          if (tag_hit && !cur_write) begin
            rsp_d = lk_data;
            nxt   = C_RESP;
          end else if (tag_hit && ((lk_state == LS_E) || (lk_state == LS_M))) begin
            wr_en    = 1'b1;
            wr_state = LS_M;
            wr_data  = cpu_req_wdata;
            rsp_d    = cpu_req_wdata;
            nxt      = C_RESP;
          end else begin
            nxt = C_ARB;
          end
        end
      end
      C_ARB: begin
        if (bus_gnt) nxt = victim_dirty ? C_WB : C_FILL;
      end
      C_WB: begin
        bus_cmd   = CMD_WB;
        bus_addr  = {lk_tag, addr_q[IDXW-1:0]};
        bus_wdata = lk_data;
        if (bus_done) begin
          wr_en    = 1'b1;
          wr_state = LS_I;
          wr_tag   = lk_tag;
          nxt      = C_FILL;
        end
      end
      C_FILL: begin
        bus_cmd = wr_q ? CMD_RDX : CMD_RD;
        if (bus_done) begin
          wr_en = 1'b1;
          if (wr_q) begin
            wr_state = LS_M;
            wr_data  = wdata_q;
            rsp_d    = wdata_q;
          end else begin
            wr_state = bus_shared_in ? LS_S : LS_E;
            wr_data  = bus_rdata;
            rsp_d    = bus_rdata;
          end
          nxt = C_RESP;
        end
      end
      C_RESP: begin
        if (cpu_rsp_ready) nxt = C_IDLE;
      end
      default: nxt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= C_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
    end else begin
      st_q  <= nxt;
      rsp_q <= rsp_d;
      if (accept) begin
        wr_q    <= cpu_req_write;
        addr_q  <= cpu_req_addr;
        wdata_q <= cpu_req_wdata;
      end
    end
  end

  assign cpu_req_ready = idle && !snp_busy;
  assign cpu_rsp_valid = (st_q == C_RESP);
  assign cpu_rsp_rdata = rsp_q;
  assign bus_req       = (st_q == C_ARB) || (st_q == C_WB) || (st_q == C_FILL);

endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int NLINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_req_write,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_rsp_valid,
  input  logic          cpu_rsp_ready,
  output logic [DW-1:0] cpu_rsp_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared_out,
  output logic          snp_flush,
  output logic [DW-1:0] snp_flush_data
);

  localparam int IDXW = $clog2(NLINES);
  localparam int TAGW = AW - IDXW;

  logic [IDXW-1:0] lk_idx;
  line_state_e     lk_state, sn_state, wr_state, upd_state;
  logic [TAGW-1:0] lk_tag, sn_tag, wr_tag;
  logic [DW-1:0]   lk_data, sn_data, wr_data;
  logic            wr_en, upd_en;

  mesi_line_array #(
    .NLINES(NLINES), .IDXW(IDXW), .TAGW(TAGW), .DW(DW)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_idx   (lk_idx),
    .a_state (lk_state),
    .a_tag   (lk_tag),
    .a_data  (lk_data),
    .b_idx   (snp_addr[IDXW-1:0]),
    .b_state (sn_state),
    .b_tag   (sn_tag),
    .b_data  (sn_data),
    .c_we    (wr_en),
    .c_idx   (lk_idx),
    .c_state (wr_state),
    .c_tag   (wr_tag),
    .c_data  (wr_data),
    .s_we    (upd_en),
    .s_idx   (snp_addr[IDXW-1:0]),
    .s_state (upd_state)
  );

  mesi_snoop_unit #(
    .TAGW(TAGW), .DW(DW)
  ) u_snoop (
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_tag    (snp_addr[AW-1:IDXW]),
    .ln_state   (sn_state),
    .ln_tag     (sn_tag),
    .ln_data    (sn_data),
    .shared_out (snp_shared_out),
    .flush      (snp_flush),
    .flush_data (snp_flush_data),
    .upd_en     (upd_en),
    .upd_state  (upd_state)
  );

  mesi_ctrl #(
    .AW(AW), .DW(DW), .IDXW(IDXW), .TAGW(TAGW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_ready (cpu_rsp_ready),
    .cpu_rsp_rdata (cpu_rsp_rdata),
    .snp_busy      (snp_valid),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd       (bus_cmd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_done      (bus_done),
    .bus_rdata     (bus_rdata),
    .bus_shared_in (bus_shared_in),
    .lk_idx        (lk_idx),
    .lk_state      (lk_state),
    .lk_tag        (lk_tag),
    .lk_data       (lk_data),
    .wr_en         (wr_en),
    .wr_state      (wr_state),
    .wr_tag        (wr_tag),
    .wr_data       (wr_data)
  );

endmodule

// File: rtl/mesi_checker.sv
module mesi_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req_ready,
  input logic          cpu_rsp_valid,
  input logic          cpu_rsp_ready,
  input logic [DW-1:0] cpu_rsp_rdata,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [1:0]    bus_cmd,
  input logic          bus_done,
  input logic          snp_valid,
  input logic [1:0]    snp_cmd,
  input logic          snp_shared_out,
  input logic          snp_flush
);

  // R6: shared indication only answers a snooped bus read
  assert_shared_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared_out |-> (snp_valid && (snp_cmd == 2'd1)));

  // R7 / R8: data is flushed only in answer to a snooped read or read-for-ownership
  assert_flush_on_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && ((snp_cmd == 2'd1) || (snp_cmd == 2'd2))));

  // R5 / R10: commands are driven only while the bus is requested and granted
  assert_cmd_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> (bus_gnt && bus_req));

  // R10: a command stays on the bus until its done pulse
  assert_cmd_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_cmd != 2'd0) && !bus_done) |=> (bus_cmd == $past(bus_cmd)));

  // R11: a stalled response keeps valid and data
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));

  // R11: no request is taken during a snoop cycle
  assert_no_accept_in_snoop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_req_ready);

  // R11: no request is taken while a response is pending
  assert_no_accept_in_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !cpu_req_ready);

endmodule

bind mesi_cache_ctrl mesi_checker #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_req_ready  (cpu_req_ready),
  .cpu_rsp_valid  (cpu_rsp_valid),
  .cpu_rsp_ready  (cpu_rsp_ready),
  .cpu_rsp_rdata  (cpu_rsp_rdata),
  .bus_req        (bus_req),
  .bus_gnt        (bus_gnt),
  .bus_cmd        (bus_cmd),
  .bus_done       (bus_done),
  .snp_valid      (snp_valid),
  .snp_cmd        (snp_cmd),
  .snp_shared_out (snp_shared_out),
  .snp_flush      (snp_flush)
);

// File: tb/tb_mesi_cache_ctrl.sv
module tb_mesi_cache_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_write = 1'b0;
  logic [7:0]  cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic        cpu_rsp_ready = 1'b1;
  logic [31:0] cpu_rsp_rdata;
  logic        bus_req;
  logic        bus_gnt;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_done;
  logic [31:0] bus_rdata;
  logic        bus_shared_in = 1'b0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = '0;
  logic [7:0]  snp_addr = '0;
  logic        snp_shared_out;
  logic        snp_flush;
  logic [31:0] snp_flush_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mesi_cache_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
    .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared_out(snp_shared_out), .snp_flush(snp_flush),
    .snp_flush_data(snp_flush_data)
  );

  // bus arbiter and memory model
  logic [31:0] mem [256];
  logic        busy;
  logic [1:0]  lat_cnt;
  logic [1:0]  cmd_l;
  logic [7:0]  addr_l;
  logic [31:0] wd_l;
  int          cnt_rd, cnt_rdx, cnt_wb;
  logic [7:0]  last_wb_addr;
  logic [31:0] last_wb_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0; bus_done <= 1'b0; bus_rdata <= '0;
      busy <= 1'b0; lat_cnt <= '0; cmd_l <= '0; addr_l <= '0; wd_l <= '0;
      cnt_rd <= 0; cnt_rdx <= 0; cnt_wb <= 0;
      last_wb_addr <= '0; last_wb_data <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA500_0000 | i;
    end else begin
      bus_gnt  <= bus_req;
      bus_done <= 1'b0;
      if (snp_flush) mem[snp_addr] <= snp_flush_data;
      if (busy) begin
        if (lat_cnt == 2'd0) begin
          busy     <= 1'b0;
          bus_done <= 1'b1;
          case (cmd_l)
            2'd1: begin bus_rdata <= mem[addr_l]; cnt_rd  <= cnt_rd + 1;  end
            2'd2: begin bus_rdata <= mem[addr_l]; cnt_rdx <= cnt_rdx + 1; end
            2'd3: begin
              mem[addr_l]  <= wd_l; cnt_wb <= cnt_wb + 1;
              last_wb_addr <= addr_l; last_wb_data <= wd_l;
            end
            default: ;
          endcase
        end else begin
          lat_cnt <= lat_cnt - 2'd1;
        end
      end else if (bus_gnt && (bus_cmd != 2'd0) && !bus_done) begin
        busy <= 1'b1; lat_cnt <= 2'd1;
        cmd_l <= bus_cmd; addr_l <= bus_addr; wd_l <= bus_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 1;
    while (!cpu_rsp_valid) begin @(negedge clk); lat++; end
    rd = cpu_rsp_rdata;
    @(posedge clk);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a,
                       output logic sh, output logic fl, output logic [31:0] fd);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1;
    sh = snp_shared_out; fl = snp_flush; fd = snp_flush_data;
    @(posedge clk);
    #1;
    snp_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic sh, fl; logic [31:0] fd;
    @(negedge clk);
    chk("R1 ready after reset", 32'(cpu_req_ready), 32'd1);
    chk("R1 no response after reset", 32'(cpu_rsp_valid), 32'd0);
    chk("R1 no bus request after reset", 32'(bus_req), 32'd0);
    snoop(2'd1, 8'h10, sh, fl, fd);
    chk("R1 R6 no shared on empty cache", 32'(sh), 32'd0);
    chk("R1 no flush on empty cache", 32'(fl), 32'd0);
  endtask

  task automatic t_exclusive_path;
    logic [31:0] rd, fd; int lat, b_rd, b_rdx;
    logic sh, fl;
    bus_shared_in = 1'b0;
    b_rd = cnt_rd;
    cpu_op(1'b0, 8'h10, '0, rd, lat);
    chk("R1 R2 read miss data", rd, 32'hA500_0010);
    chk("R1 R2 read miss issues bus read", 32'(cnt_rd - b_rd), 32'd1);
    b_rd = cnt_rd; b_rdx = cnt_rdx;
    cpu_op(1'b0, 8'h10, '0, rd, lat);
    chk("R3 read hit data", rd, 32'hA500_0010);
    chk("R3 read hit latency", 32'(lat), 32'd1);
    chk("R3 read hit no bus", 32'(cnt_rd - b_rd + cnt_rdx - b_rdx), 32'd0);
    cpu_op(1'b1, 8'h10, 32'h1111_1111, rd, lat);
    chk("R4 silent store latency", 32'(lat), 32'd1);
    chk("R2 R4 store to exclusive no bus", 32'(cnt_rd - b_rd + cnt_rdx - b_rdx), 32'd0);
    snoop(2'd1, 8'h10, sh, fl, fd);
    chk("R6 shared on modified hit", 32'(sh), 32'd1);
    chk("R4 R7 flush on snooped read of modified", 32'(fl), 32'd1);
    chk("R7 flush data", fd, 32'h1111_1111);
    snoop(2'd1, 8'h10, sh, fl, fd);
    chk("R7 line now shared: no flush", 32'(fl), 32'd0);
    chk("R6 R7 line now shared: shared set", 32'(sh), 32'd1);
    b_rdx = cnt_rdx;
    cpu_op(1'b1, 8'h10, 32'h2222_2222, rd, lat);
    chk("R5 store to shared issues read-for-ownership", 32'(cnt_rdx - b_rdx), 32'd1);
    snoop(2'd2, 8'h10, sh, fl, fd);
    chk("R8 flush on snooped rdx of modified", 32'(fl), 32'd1);
    chk("R5 R8 flush data holds stored word", fd, 32'h2222_2222);
    chk("R6 no shared on rdx", 32'(sh), 32'd0);
    b_rd = cnt_rd;
    cpu_op(1'b0, 8'h10, '0, rd, lat);
    chk("R8 line invalid: read misses", 32'(cnt_rd - b_rd), 32'd1);
    chk("R8 refetched data", rd, 32'h2222_2222);
  endtask

  task automatic t_shared_path;
    logic [31:0] rd, fd; int lat, b_rd, b_rdx;
    logic sh, fl;
    bus_shared_in = 1'b1;
    cpu_op(1'b0, 8'h11, '0, rd, lat);
    chk("R2 read miss data with shared set", rd, 32'hA500_0011);
    bus_shared_in = 1'b0;
    b_rdx = cnt_rdx;
    cpu_op(1'b1, 8'h11, 32'h3333_3333, rd, lat);
    chk("R2 R5 fill as shared then store needs rdx", 32'(cnt_rdx - b_rdx), 32'd1);
    cpu_op(1'b0, 8'h12, '0, rd, lat);
    snoop(2'd1, 8'h12, sh, fl, fd);
    chk("R6 R9 shared on exclusive hit", 32'(sh), 32'd1);
    chk("R9 no flush on exclusive", 32'(fl), 32'd0);
    b_rdx = cnt_rdx;
    cpu_op(1'b1, 8'h12, 32'h4444_0000, rd, lat);
    chk("R9 exclusive demoted: store needs rdx", 32'(cnt_rdx - b_rdx), 32'd1);
    cpu_op(1'b0, 8'h13, '0, rd, lat);
    snoop(2'd2, 8'h13, sh, fl, fd);
    chk("R9 no flush rdx on exclusive", 32'(fl), 32'd0);
    b_rd = cnt_rd;
    cpu_op(1'b0, 8'h13, '0, rd, lat);
    chk("R9 exclusive invalidated by rdx", 32'(cnt_rd - b_rd), 32'd1);
    snoop(2'd1, 8'h23, sh, fl, fd);
    chk("R6 no shared on tag mismatch", 32'(sh), 32'd0);
  endtask

  task automatic t_evict;
    logic [31:0] rd; int lat, b_rd, b_wb;
    cpu_op(1'b1, 8'h10, 32'h5555_5555, rd, lat);
    b_rd = cnt_rd; b_wb = cnt_wb;
    cpu_op(1'b0, 8'h20, '0, rd, lat);
    chk("R10 dirty victim written back", 32'(cnt_wb - b_wb), 32'd1);
    chk("R10 writeback address", 32'(last_wb_addr), 32'h10);
    chk("R10 writeback data", last_wb_data, 32'h5555_5555);
    chk("R10 fill after writeback", rd, 32'hA500_0020);
    b_wb = cnt_wb;
    cpu_op(1'b0, 8'h30, '0, rd, lat);
    chk("R10 clean victim dropped silently", 32'(cnt_wb - b_wb), 32'd0);
    cpu_op(1'b0, 8'h10, '0, rd, lat);
    chk("R10 memory holds written-back word", rd, 32'h5555_5555);
    chk("R10 reads issued", 32'(cnt_rd - b_rd), 32'd3);
  endtask

  task automatic t_backpressure;
    logic [31:0] first;
    // line 0x10 is resident (exclusive) here
    @(negedge clk);
    cpu_rsp_ready = 1'b0;
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h10;
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h55;
    #1;
    chk("R11 not ready during snoop", 32'(cpu_req_ready), 32'd0);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    #1;
    chk("R11 ready after snoop", 32'(cpu_req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk("R11 response valid", 32'(cpu_rsp_valid), 32'd1);
    first = cpu_rsp_rdata;
    chk("R3 R11 response data", first, 32'h5555_5555);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 response held", 32'(cpu_rsp_valid), 32'd1);
      chk("R11 response data stable", cpu_rsp_rdata, first);
      chk("R11 not ready while response pending", 32'(cpu_req_ready), 32'd0);
    end
    cpu_rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 response released", 32'(cpu_rsp_valid), 32'd0);
    chk("R11 ready again", 32'(cpu_req_ready), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_exclusive_path();
    t_shared_path();
    t_evict();
    t_backpressure();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule